// File: doc/BRIEF.md
# Byte-Serial Master with Held Select

This block is a single-target serial master driven from a small register port. A 16-bit setup register selects the bit-clock divider, bit order, select polarity, clock polarity, sampling-edge arrangement, held-select (stream) operation, master enable, interrupt enable and the choice between two pin groups. Writing the data register sends one byte while collecting the byte returned by the target. Reading the data register returns that collected byte.

Software may keep the select line asserted across any number of bytes by setting the stream bit, and it ends the transaction by clearing that bit. With stream clear, the select is asserted only for the duration of each byte. A routing bit chooses which of two identical pin groups carries the transfer, an internal one or an external one. The unused group rests at its idle levels.

The control is a four-state machine: `ST_IDLE` (select released), `ST_SHIFT` (sixteen bit-clock half periods), `ST_TAIL` (one closing half period with the select still asserted) and `ST_HOLD` (stream mode between bytes, select held). The transitions are:
- start (a data write while enabled) moves `ST_IDLE` or `ST_HOLD` to `ST_SHIFT`.
- last_edge (the sixteenth half period) moves `ST_SHIFT` to `ST_TAIL`.
- finish (the closing half period) moves `ST_TAIL` to `ST_HOLD` when stream is set, and to `ST_IDLE` otherwise.
- release (stream cleared) moves `ST_HOLD` to `ST_IDLE`.
- abort (enable cleared) moves any state to `ST_IDLE`.

Top module: `spi_master_ctl`

## Requirements
- R1: After reset, the setup register (address 0) reads 0x0002. Both select pins are high, both clock pins are low, `irq` is low and `bus_stall` is low.
- R2: During a byte, the bit clock changes level once every P+1 system clocks, where P is setup bits 7:0. A P of 0 behaves as 1.
- R3: A write to the data register (address 1) while setup bit 13 is 1 and no byte is in flight sends the byte. Once the byte is done, a read of address 1 returns {8'h00, received byte}. A data write while bit 13 is 0, or while a byte is in flight, starts nothing and is ignored.
- R4: Setup bit 8 at 0 sends and receives the most significant bit first. At 1, the least significant bit goes first.
- R5: Setup bit 9 at 0 makes the select active low. At 1, it is active high.
- R6: Setup bit 10 gives the idle level of the bit clock. The leading edge of each bit moves the clock away from that level, and the trailing edge returns it.
- R7: Setup bit 11 at 0: the master samples MISO on the leading edge and changes MOSI on the trailing edge. At 1: the master changes MOSI and samples MISO both on the trailing edge.
- R8: While setup bit 12 is 1, the select stays asserted between consecutive bytes. Clearing bit 12 releases the select within two clocks.
- R9: With setup bit 12 at 0, the select is released after every byte.
- R10: Setup bit 15 at 1 routes the transfer to the `int_*` pins. At 0, it routes the transfer to the `ext_*` pins. The unused group holds its inactive select level, its idle clock level and MOSI at 0.
- R11: A read of address 1 while a byte is in flight holds `bus_stall` high until the byte completes.
- R12: With setup bit 14 at 1, `irq` goes high when each byte ends. Any access to address 1 clears it. With bit 14 at 0, `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | 0 = setup register, 1 = data register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| bus_stall | output | 1 | Data read not yet valid, byte in flight |
| irq | output | 1 | Byte-complete interrupt |
| ext_sck | output | 1 | External group bit clock |
| ext_cs | output | 1 | External group select |
| ext_mosi | output | 1 | External group serial out |
| ext_miso | input | 1 | External group serial in |
| int_sck | output | 1 | Internal group bit clock |
| int_cs | output | 1 | Internal group select |
| int_mosi | output | 1 | Internal group serial out |
| int_miso | input | 1 | Internal group serial in |

## Verification
The assertions assume that the setup register is not rewritten while a byte is in flight. The divider-count bound in particular relies on the divider staying fixed during a byte. The stimulus respects this by always waiting for a stalled data read to return before changing the setup. A target model in the bench follows the configured polarity, order and edge arrangement. It feeds the master a known byte and records what it receives, and it checks the unused pin group on every cycle.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int CFG_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int PRESC_W = 8;

    typedef struct packed {
        logic               route_int;
        logic               irq_en;
        logic               enable;
        logic               stream;
        logic               same_edge;
        logic               sck_inv;
        logic               cs_high;
        logic               lsb_first;
        logic [PRESC_W-1:0] presc;
    } spim_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2,
        ST_HOLD  = 2'd3
    } spim_state_t;

    localparam logic [CFG_W-1:0] CFG_RESET = 16'h0002;
endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);
    logic [PRESC_W-1:0] cnt_q;
    logic [PRESC_W-1:0] limit;

    assign limit = (presc == '0) ? PRESC_W'(1) : presc;
    assign tick  = run && (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // divider count never passes its limit while a byte is in flight
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= limit));
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         lsb_first,
    input  logic         same_edge,
    input  logic         lead_en,
    input  logic         trail_en,
    input  logic         miso,
    output logic         mosi_bit,
    output logic [W-1:0] sr
);
    logic [W-1:0] sr_q;
    logic         samp_q;
    logic         in_bit;

    assign in_bit   = same_edge ? miso : samp_q;
    assign mosi_bit = lsb_first ? sr_q[0] : sr_q[W-1];
    assign sr       = sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            samp_q <= 1'b0;
        end else begin
            if (lead_en) begin
                samp_q <= miso;
            end
            if (load) begin
                sr_q <= load_val;
            end else if (trail_en) begin
                if (lsb_first) begin
                    sr_q <= {in_bit, sr_q[W-1:1]};
                end else begin
                    sr_q <= {sr_q[W-2:0], in_bit};
                end
            end
        end
    end

    // the shift register moves only on a load or a trailing edge
    assert_shift_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !trail_en) |=> $stable(sr_q));
endmodule

// File: rtl/spim_pinmux.sv
module spim_pinmux (
    input  logic route_int,
    input  logic cs_high,
    input  logic sck_inv,
    input  logic cs_act,
    input  logic sck_base,
    input  logic mosi_bit,
    input  logic ext_miso,
    input  logic int_miso,
    output logic ext_sck,
    output logic ext_cs,
    output logic ext_mosi,
    output logic int_sck,
    output logic int_cs,
    output logic int_mosi,
    output logic miso
);
    logic cs_lvl;
    logic cs_idle;
    logic sck_lvl;

    assign cs_lvl  = cs_high ? cs_act : ~cs_act;
    assign cs_idle = ~cs_high;
    assign sck_lvl = sck_base ^ sck_inv;

    always_comb begin
        if (route_int) begin
            int_sck  = sck_lvl;
            int_cs   = cs_lvl;
            int_mosi = mosi_bit;
            ext_sck  = sck_inv;
            ext_cs   = cs_idle;
            ext_mosi = 1'b0;
            miso     = int_miso;
        end else begin
            ext_sck  = sck_lvl;
            ext_cs   = cs_lvl;
            ext_mosi = mosi_bit;
            int_sck  = sck_inv;
            int_cs   = cs_idle;
            int_mosi = 1'b0;
            miso     = ext_miso;
        end
    end
endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl
    import spim_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_addr,
    input  logic [CFG_W-1:0] bus_wdata,
    output logic [CFG_W-1:0] bus_rdata,
    output logic             bus_stall,
    output logic             irq,
    output logic             ext_sck,
    output logic             ext_cs,
    output logic             ext_mosi,
    input  logic             ext_miso,
    output logic             int_sck,
    output logic             int_cs,
    output logic             int_mosi,
    input  logic             int_miso
);
    localparam int EDGES  = 2 * W;
    localparam int EDGE_W = $clog2(EDGES) + 1;
    localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(EDGES - 1);

    spim_cfg_t   cfg_q;
    spim_state_t state_q, state_d;
    logic [EDGE_W-1:0] edge_q;
    logic         sck_q;
    logic [W-1:0] rx_q;
    logic         irq_q;
    logic         tick, busy, start, data_acc, lead, trail, last_edge, finish;
    logic         cs_act, mosi_bit, mosi_gated, miso;
    logic [W-1:0] sr;

    assign busy      = (state_q == ST_SHIFT) || (state_q == ST_TAIL);
    assign data_acc  = (bus_wr || bus_rd) && bus_addr;
    assign start     = bus_wr && bus_addr && cfg_q.enable &&
                       ((state_q == ST_IDLE) || (state_q == ST_HOLD));
    assign lead      = (state_q == ST_SHIFT) && tick && !sck_q;
    assign trail     = (state_q == ST_SHIFT) && tick && sck_q;
    assign last_edge = trail && (edge_q == EDGE_LAST);
    assign finish    = (state_q == ST_TAIL) && tick;

    // setup register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= spim_cfg_t'(CFG_RESET);
        end else if (bus_wr && !bus_addr) begin
            cfg_q <= spim_cfg_t'(bus_wdata);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_SHIFT;
            ST_SHIFT: if (last_edge) state_d = ST_TAIL;
            ST_TAIL:  if (finish) state_d = cfg_q.stream ? ST_HOLD : ST_IDLE;
            ST_HOLD: begin
                if (!cfg_q.stream) state_d = ST_IDLE;
                else if (start)    state_d = ST_SHIFT;
            end
            default:  state_d = ST_IDLE;
        endcase
        if (!cfg_q.enable) state_d = ST_IDLE;
    end

    // outputs: bit clock, edge count, received byte, interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            edge_q <= '0;
            rx_q   <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (state_q != ST_SHIFT) begin
                sck_q  <= 1'b0;
                edge_q <= '0;
            end else if (tick) begin
                sck_q  <= ~sck_q;
                edge_q <= edge_q + 1'b1;
            end
            if (finish) begin
                rx_q <= sr;
            end
            if (finish && cfg_q.irq_en) begin
                irq_q <= 1'b1;
            end else if (data_acc) begin
                irq_q <= 1'b0;
            end
        end
    end

    assign cs_act     = (state_q != ST_IDLE);
    assign mosi_gated = busy && mosi_bit;
    assign bus_stall  = bus_rd && bus_addr && busy;
    assign bus_rdata  = bus_addr ? {{(CFG_W-W){1'b0}}, rx_q} : CFG_W'(cfg_q);
    assign irq        = irq_q;

    spim_baud #(.PRESC_W(PRESC_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .presc (cfg_q.presc),
        .tick  (tick)
    );

    spim_shifter #(.W(W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_val  (bus_wdata[W-1:0]),
        .lsb_first (cfg_q.lsb_first),
        .same_edge (cfg_q.same_edge),
        .lead_en   (lead),
        .trail_en  (trail),
        .miso      (miso),
        .mosi_bit  (mosi_bit),
        .sr        (sr)
    );

    spim_pinmux u_pins (
        .route_int (cfg_q.route_int),
        .cs_high   (cfg_q.cs_high),
        .sck_inv   (cfg_q.sck_inv),
        .cs_act    (cs_act),
        .sck_base  (sck_q),
        .mosi_bit  (mosi_gated),
        .ext_miso  (ext_miso),
        .int_miso  (int_miso),
        .ext_sck   (ext_sck),
        .ext_cs    (ext_cs),
        .ext_mosi  (ext_mosi),
        .int_sck   (int_sck),
        .int_cs    (int_cs),
        .int_mosi  (int_mosi),
        .miso      (miso)
    );

    // unused external group rests idle when routed inside
    assert_ext_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.route_int |-> (ext_cs == !cfg_q.cs_high && ext_sck == cfg_q.sck_inv && !ext_mosi));

    // clearing stream in the hold state releases the select next cycle
    assert_hold_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !cfg_q.stream) |=> (state_q == ST_IDLE));

    // interrupt only rises when enabled
    assert_irq_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cfg_q.irq_en));

    // the closing half period sees the clock back at idle
    assert_tail_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAIL) |-> !sck_q);
endmodule

// File: tb/spi_master_ctl_bench.sv
module spi_master_ctl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {setup, byte sent by master, byte sent by target}
    localparam logic [31:0] VEC [NVEC] = '{
        {16'h2002, 8'hA5, 8'h3C},
        {16'h2102, 8'h81, 8'h17},
        {16'h2602, 8'h5A, 8'hC3},
        {16'h2800, 8'h96, 8'h01},
        {16'h2D03, 8'hF0, 8'h0F},
        {16'hA001, 8'h33, 8'hE8},
        {16'hAB05, 8'h7E, 8'h42},
        {16'h2001, 8'h00, 8'hFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic bus_stall, irq;
    logic ext_sck, ext_cs, ext_mosi, ext_miso;
    logic int_sck, int_cs, int_mosi, int_miso;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [15:0] cur_cfg = 16'h0002;
    logic [7:0]  slave_tx = '0, slave_rx = '0;
    logic [2:0]  k = '0, hold_k = '0;
    logic        sel_prev = 1'b0, sck_prev = 1'b0;
    int          releases = 0, selects = 0, idle_bad = 0, gap = 0, cyc = 0, lead_cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_master_ctl u_spi_master_ctl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_stall(bus_stall), .irq(irq),
        .ext_sck(ext_sck), .ext_cs(ext_cs), .ext_mosi(ext_mosi), .ext_miso(ext_miso),
        .int_sck(int_sck), .int_cs(int_cs), .int_mosi(int_mosi), .int_miso(int_miso)
    );

    function automatic logic [2:0] bidx(input logic [2:0] n);
        return cur_cfg[8] ? n : 3'd7 - n;
    endfunction

    wire s_sck  = cur_cfg[15] ? int_sck  : ext_sck;
    wire s_cs   = cur_cfg[15] ? int_cs   : ext_cs;
    wire s_mosi = cur_cfg[15] ? int_mosi : ext_mosi;
    wire u_sck  = cur_cfg[15] ? ext_sck  : int_sck;
    wire u_cs   = cur_cfg[15] ? ext_cs   : int_cs;
    wire u_mosi = cur_cfg[15] ? ext_mosi : int_mosi;
    wire s_miso = cur_cfg[11] ? slave_tx[bidx(hold_k)] : slave_tx[bidx(k)];
    assign int_miso = cur_cfg[15] ? s_miso : ~s_miso;
    assign ext_miso = cur_cfg[15] ? ~s_miso : s_miso;

    // target model, sampled away from the active edge
    always @(negedge clk) begin
        logic sel;
        cyc = cyc + 1;
        sel = cur_cfg[9] ? s_cs : ~s_cs;
        if (sel && !sel_prev) begin k = '0; selects = selects + 1; end
        if (!sel && sel_prev) releases = releases + 1;
        if (sel && s_sck != sck_prev) begin
            if (s_sck != cur_cfg[10]) begin
                slave_rx[bidx(k)] = s_mosi;
                hold_k = k;
                k = k + 1'b1;
                lead_cyc = cyc;
            end else begin
                gap = cyc - lead_cyc;
            end
        end
        if (rst_n && (u_cs != !cur_cfg[9] || u_sck != cur_cfg[10] || u_mosi != 1'b0))
            idle_bad = idle_bad + 1;
        sck_prev = s_sck;
        sel_prev = sel;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (!a) cur_cfg = d;
    endtask

    task automatic bus_read(input logic a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        while (bus_stall) begin @(negedge clk); #1; end
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=0x0 expected=0x1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        int r0, s0, hp;
        bit cs_seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ext_cs == 1'b1 && int_cs == 1'b1, "R1 select idle", {ext_cs, int_cs}, 2'b11);
        chk(ext_sck == 1'b0 && int_sck == 1'b0, "R1 clock idle", {ext_sck, int_sck}, 0);
        chk(irq == 1'b0 && bus_stall == 1'b0, "R1 irq/stall", {irq, bus_stall}, 0);
        bus_read(1'b0, rd);
        chk(rd == 16'h0002, "R1 setup reset", rd, 16'h0002);

        // table of single-byte transfers across modes
        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] c;
            logic [7:0] tx, stx;
            {c, tx, stx} = VEC[i];
            bus_write(1'b0, c);
            @(negedge clk);
            chk(s_cs == !c[9], "R5 select inactive level", s_cs, !c[9]);
            chk(s_sck == c[10], "R6 clock idle level", s_sck, c[10]);
            slave_tx = stx;
            idle_bad = 0;
            bus_write(1'b1, {8'h00, tx});
            bus_read(1'b1, rd);
            chk(rd == {8'h00, stx}, "R3/R4/R7 received byte", rd, stx);
            chk(slave_rx == tx, "R4/R7 byte seen by target", slave_rx, tx);
            hp = (c[7:0] == 0) ? 2 : c[7:0] + 1;
            chk(gap == hp, "R2 half period", gap, hp);
            chk(idle_bad == 0, "R10 unused group idle", idle_bad, 0);
            @(negedge clk);
            chk(s_cs == !c[9], "R9 select released", s_cs, !c[9]);
        end

        // R3 data write while disabled is ignored
        bus_write(1'b0, 16'h0002);
        s0 = selects;
        cs_seen = 0;
        bus_write(1'b1, 16'h0055);
        repeat (40) begin @(negedge clk); if (ext_cs == 1'b0) cs_seen = 1; end
        chk(!cs_seen && selects == s0, "R3 disabled write ignored", selects - s0, 0);
        bus_read(1'b1, rd);
        chk(rd == 16'h00FF, "R3 disabled keeps old byte", rd, 16'h00FF);

        // R3 write while busy is ignored; R11 stall while in flight
        bus_write(1'b0, 16'h2004);
        slave_tx = 8'h22;
        bus_write(1'b1, 16'h0011);
        bus_write(1'b1, 16'h0099);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 1'b1;
        #1;
        chk(bus_stall == 1'b1, "R11 stall in flight", bus_stall, 1);
        @(negedge clk);
        bus_rd = 1'b0;
        bus_read(1'b1, rd);
        chk(rd == 16'h0022, "R3 busy write ignored (rx)", rd, 16'h0022);
        chk(slave_rx == 8'h11, "R3 busy write ignored (tx)", slave_rx, 8'h11);
        chk(bus_stall == 1'b0, "R11 stall cleared", bus_stall, 0);

        // R8 stream: select held across three bytes
        bus_write(1'b0, 16'h3002);
        r0 = releases;
        for (int b = 0; b < 3; b++) begin
            slave_tx = 8'h10 + 8'(b);
            bus_write(1'b1, 16'h00C0 + 16'(b));
            bus_read(1'b1, rd);
            chk(rd == {8'h00, 8'h10 + 8'(b)}, "R8 stream byte", rd, 8'h10 + b);
        end
        repeat (5) @(negedge clk);
        chk(releases == r0 && ext_cs == 1'b0, "R8 select held", releases - r0, 0);
        bus_write(1'b0, 16'h2002);
        repeat (2) @(negedge clk);
        chk(ext_cs == 1'b1 && releases == r0 + 1, "R8 select released", releases - r0, 1);

        // R9 non-stream releases after each byte
        r0 = releases;
        for (int b = 0; b < 2; b++) begin
            bus_write(1'b1, 16'h0042);
            bus_read(1'b1, rd);
        end
        @(negedge clk);
        chk(releases == r0 + 2, "R9 release per byte", releases - r0, 2);

        // R12 interrupt
        bus_write(1'b0, 16'h6002);
        slave_tx = 8'h6B;
        bus_write(1'b1, 16'h0001);
        for (int n = 0; n < 200 && !irq; n++) @(negedge clk);
        chk(irq == 1'b1, "R12 irq raised", irq, 1);
        bus_read(1'b1, rd);
        chk(irq == 1'b0, "R12 irq cleared by access", irq, 0);
        bus_write(1'b0, 16'h2002);
        bus_write(1'b1, 16'h0003);
        bus_read(1'b1, rd);
        repeat (4) @(negedge clk);
        chk(irq == 1'b0, "R12 irq stays low when disabled", irq, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule